// File: doc/BRIEF.md
# Eight-Modulus Prescaler

This block is a programmable integer divider for the feedback path of a frequency synthesizer. It divides its input clock by any of eight consecutive ratios, 67 through 74, with 70 as the nominal ratio. A 3-bit select code picks the ratio: ratio = 67 + code. The block emits a one-clock pulse at the end of each completed output period.

All eight ratios come from a single dual-modulus divide-by-8/9 core. The core is a synchronous 4/5 sub-counter followed by a toggle stage, so each core cycle is made of two sub-divisions of 4 or 5 input clocks. A 3-bit extender counts eight core cycles per output period. Control logic chooses, for each core cycle, whether it lasts 8, 9 or 10 input clocks. Ratios below 72 shorten some core cycles to 8. Ratio 72 runs all eight at 9. Ratios 73 and 74 stretch one or two core cycles to 10 by also lengthening the first sub-division.

The select code is captured once per output period. Any later change therefore affects only the following period and never yields a partial or mixed period.

Top module: `eightModPrescaler`

## Requirements
- R1: While `rstN` is low, `divOut` and `coreTgl` are both 0.
- R2: With select code c (0..7) on `modSel`, consecutive rising edges of `divOut` are exactly 67 + c input clock cycles apart.
- R3: `divOut` is high for exactly one input clock cycle per output period.
- R4: The select code for a period is sampled at the rising clock edge at which `divOut` is high. After reset, it is sampled at the first rising edge instead. Changes to `modSel` at any other time have no effect on the period in progress.
- R5: `coreTgl` is low during the first sub-division of each core cycle and high during the second. It falls at the end of every core cycle. Each output period holds eight core cycles, and `divOut` rises on the same edge as the eighth fall.
- R6: For codes 0..4, the first 5 − c core cycles of a period last 8 clocks and the rest last 9.
- R7: For code 5 (ratio 72), all eight core cycles last 9 clocks.
- R8: For codes 6 and 7, the first c − 5 core cycles last 10 clocks and the rest last 9.
- R9: `coreTgl` stays high for 4 clocks in an 8-clock core cycle and for 5 clocks in a 9- or 10-clock core cycle.
- R10: After reset is released, the first rising edge of `divOut` follows the (67 + c)-th rising clock edge, counting the first edge after release as edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| modSel | input | 3 | Ratio select code; ratio = 67 + code |
| divOut | output | 1 | One-clock pulse ending each output period |
| coreTgl | output | 1 | Toggle-stage output of the 8/9 core |

## Verification
The hardest case is a select change that lands inside a period, and in particular on the first clock after capture, when the period has just latched its code. The stimulus sets the code on the falling edge where `divOut` is seen high. It then scrambles `modSel` on the very next falling edge and on random later ones. The period length and the per-core-cycle lengths must still match the code captured at the pulse. The stretched ratios 73 and 74 come only from codes 6 and 7. The bench visits them both in sweeps and in abrupt jumps from code 0, so it checks the 10-clock core cycles and their placement at the start of the period.

// File: rtl/prescPkg.sv
package prescPkg;
  // Per-core-cycle swallow controls sent from the control to the datapath.
  // lengthen : stretch the second sub-division to SUB_LEN+1 (core /9)
  // stretch  : stretch both sub-divisions to SUB_LEN+1 (core /10)
  typedef struct packed {
    logic lengthen;
    logic stretch;
  } swallowCtl_t;
endpackage

// File: rtl/dualModCore.sv
module dualModCore
  import prescPkg::*;
#(
  parameter int SUB_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  swallowCtl_t swCtl,
  output logic        tglQ,
  output logic        coreEnd
);
  localparam int CNT_W = $clog2(SUB_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SUB_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(SUB_LEN);

  logic [CNT_W-1:0] subCnt;
  logic             longSub;
  logic             subEnd;

  // 4/5 sub-counter: the long count applies in the second half for /9,
  // and in both halves for /10.
  always_comb begin
    longSub = swCtl.stretch | (swCtl.lengthen & tglQ);
    subEnd  = (subCnt == (longSub ? LAST_LONG : LAST_SHORT));
    coreEnd = subEnd & tglQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      tglQ   <= 1'b0;
    end else begin
      subCnt <= subEnd ? '0 : subCnt + 1'b1;
      if (subEnd) tglQ <= ~tglQ;
    end
  end
endmodule

// File: rtl/modCtrl.sv
module modCtrl
  import prescPkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int BASE_RATIO = 67,
  parameter int SUB_LEN    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] modSel,
  input  logic             coreEnd,
  output swallowCtl_t      swCtl,
  output logic             divOut
);
  localparam int CYC       = 1 << SEL_W;
  localparam int FULL      = CYC * (2 * SUB_LEN + 1);
  localparam int FULL_CODE = FULL - BASE_RATIO;

  logic [SEL_W-1:0] selQ;
  logic [SEL_W-1:0] curSel;
  logic [SEL_W-1:0] coreIdx;
  logic             periodStart;
  logic             lastCore;
  int               nShort;
  int               nLong;

  always_comb begin
    curSel = periodStart ? modSel : selQ;
    if (int'(curSel) <= FULL_CODE) begin
      nShort = FULL_CODE - int'(curSel);
      nLong  = 0;
    end else begin
      nShort = 0;
      nLong  = int'(curSel) - FULL_CODE;
    end
    swCtl.stretch  = int'(coreIdx) < nLong;
    swCtl.lengthen = !swCtl.stretch && !(int'(coreIdx) < nShort);
    lastCore       = (coreIdx == SEL_W'(CYC - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreIdx     <= '0;
      selQ        <= '0;
      periodStart <= 1'b1;
      divOut      <= 1'b0;
    end else begin
      if (coreEnd) coreIdx <= coreIdx + 1'b1;
      if (periodStart) selQ <= modSel;
      periodStart <= coreEnd & lastCore;
      divOut      <= coreEnd & lastCore;
    end
  end
endmodule

// File: rtl/eightModPrescaler.sv
module eightModPrescaler
  import prescPkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int BASE_RATIO = 67,
  parameter int SUB_LEN    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] modSel,
  output logic             divOut,
  output logic             coreTgl
);
  swallowCtl_t swCtl;
  logic        coreEnd;

  dualModCore #(.SUB_LEN(SUB_LEN)) coreI (
    .clk    (clk),
    .rstN   (rstN),
    .swCtl  (swCtl),
    .tglQ   (coreTgl),
    .coreEnd(coreEnd)
  );

  modCtrl #(
    .SEL_W     (SEL_W),
    .BASE_RATIO(BASE_RATIO),
    .SUB_LEN   (SUB_LEN)
  ) ctrlI (
    .clk    (clk),
    .rstN   (rstN),
    .modSel (modSel),
    .coreEnd(coreEnd),
    .swCtl  (swCtl),
    .divOut (divOut)
  );
endmodule

// File: rtl/eightModPrescalerChk.sv
module eightModPrescalerChk #(
  parameter int SEL_W      = 3,
  parameter int BASE_RATIO = 67,
  parameter int SUB_LEN    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] modSel,
  input logic             divOut,
  input logic             coreTgl
);
  localparam int FULL_CODE = (1 << SEL_W) * (2 * SUB_LEN + 1) - BASE_RATIO;

  logic [7:0]       perCnt;
  logic [7:0]       tCnt;
  logic [SEL_W-1:0] capSel;
  logic             startQ;
  logic             tglQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt <= '0;
      tCnt   <= '0;
      capSel <= '0;
      startQ <= 1'b1;
      tglQ   <= 1'b0;
    end else begin
      if (startQ || divOut) begin
        perCnt <= 8'd1;
        capSel <= modSel;
        startQ <= 1'b0;
      end else begin
        perCnt <= perCnt + 8'd1;
      end
      tCnt <= (tglQ && !coreTgl) ? 8'd1 : tCnt + 8'd1;
      tglQ <= coreTgl;
    end
  end

  assert_ratio_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divOut) |-> (int'(perCnt) == BASE_RATIO + int'(capSel)));

  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut);

  assert_align_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divOut) |-> $fell(coreTgl));

  assert_no_stretch_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(coreTgl) && int'(capSel) < FULL_CODE) |-> (tCnt != 8'd10));

  assert_all_nine_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(coreTgl) && int'(capSel) == FULL_CODE) |-> (tCnt == 8'd9));

  assert_no_short_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(coreTgl) && int'(capSel) > FULL_CODE) |-> (tCnt != 8'd8));

  assert_core_len_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreTgl) |-> (tCnt >= 8'd8 && tCnt <= 8'd10));
endmodule

bind eightModPrescaler eightModPrescalerChk chkI (
  .clk    (clk),
  .rstN   (rstN),
  .modSel (modSel),
  .divOut (divOut),
  .coreTgl(coreTgl)
);

// File: tb/eightModPrescaler_test.sv
module eightModPrescaler_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modSel = 3'd0;
  logic       divOut;
  logic       coreTgl;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  eightModPrescaler uut (
    .clk    (clk),
    .rstN   (rstN),
    .modSel (modSel),
    .divOut (divOut),
    .coreTgl(coreTgl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int coreLenExp(input int code, input int idx);
    if (code <= 5) return (idx < 5 - code) ? 8 : 9;
    return (idx < code - 5) ? 10 : 9;
  endfunction

  // Starts at a negedge where a period has just begun (pulse seen or reset
  // released); runs until the next pulse is seen on a negedge.
  task automatic runPeriod(input int code, input bit wiggle, input string ratioReq);
    int n = 0;
    int lastFall = 0;
    int idx = 0;
    int hi = 0;
    bit prevTgl = 1'b0;
    string lenReq = (code <= 4) ? "R6" : ((code == 5) ? "R7" : "R8");
    while (1) begin
      @(negedge clk);
      n++;
      if (coreTgl) hi++;
      if (prevTgl && !coreTgl) begin
        if (idx < 8) begin
          check((n - lastFall) == coreLenExp(code, idx), lenReq, n - lastFall,
                coreLenExp(code, idx));
          check(hi == ((coreLenExp(code, idx) == 8) ? 4 : 5), "R9", hi,
                (coreLenExp(code, idx) == 8) ? 4 : 5);
        end
        idx++;
        lastFall = n;
        hi = 0;
      end
      prevTgl = coreTgl;
      if (n == 1) check(divOut == 1'b0, "R3", int'(divOut), 0);
      if (wiggle && !divOut && (n == 1 || ($urandom % 3) == 0)) modSel = 3'($urandom);
      if (divOut || n >= 200) break;
    end
    check(n == 67 + code, ratioReq, n, 67 + code);
    check(idx == 8 && lastFall == n, "R5", idx, 8);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    modSel = 3'd6;
    repeat (3) @(negedge clk);
    check(divOut == 1'b0, "R1", int'(divOut), 0);
    check(coreTgl == 1'b0, "R1", int'(coreTgl), 0);
    modSel = 3'd2;
    rstN = 1'b1;
    runPeriod(2, 1'b0, "R10");
  endtask

  task automatic testSweep();
    for (int c = 0; c < 8; c++) begin
      modSel = 3'(c);
      runPeriod(c, 1'b0, "R2");
      runPeriod(c, 1'b0, "R2");
    end
  endtask

  task automatic testJumps();
    int seq[6] = '{0, 7, 0, 6, 5, 1};
    foreach (seq[i]) begin
      modSel = 3'(seq[i]);
      runPeriod(seq[i], 1'b0, "R2");
    end
  endtask

  task automatic testMidChange();
    for (int k = 0; k < 16; k++) begin
      int code = int'($urandom % 8);
      modSel = 3'(code);
      runPeriod(code, 1'b1, "R4");
    end
  endtask

  initial begin
    testReset();
    testSweep();
    testJumps();
    testMidChange();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule